// File: doc/BRIEF.md
# Selectable-strength Reed-Solomon encoder

This block is a systematic Reed-Solomon encoder over GF(2^8). It is built for links that need to trade payload against error-correction strength while running. A 2-bit strength selector picks one of four shortened codes. Each code has its own message length k and its own parity count 2t, with t set to 7, 8, 9 or 10. Message bytes stream in one per beat over a valid/ready interface. The first byte is marked with a start flag and the final message byte with an end flag. The bytes leave on the output stream unchanged and in the same cycle. After the final message byte the block appends the 2t parity bytes and flags the last one.

A single 20-stage division register carries the remainder for every strength. Only the lowest 2t stages take part in a given mode, and the stages above them stay at zero. The generator coefficients are computed when the design is elaborated, for all four strengths. The selector is captured on the start beat, so the strength of a codeword cannot change part-way through it.

Back-pressure rules are as follows. While the message is flowing, in_ready follows out_ready and every byte passes through combinationally. While parity is being sent, in_ready is low, out_valid stays high, and a parity byte is held until out_ready takes it. Between codewords, a byte without the start flag is accepted and dropped, and a start byte waits for out_ready. If the number of message bytes up to the end flag differs from the selected k, a length-error flag is raised and parity is still produced.

Top module: `rs_sel_enc`

## Requirements
- R1: In the message phase each accepted input byte appears on out_data in the same cycle without change. In that phase out_valid equals in_valid and in_ready equals out_ready.
- R2: After the byte carrying in_eom is accepted, exactly 2t parity bytes are output. The count is 14, 16, 18 or 20 for strength codes 0, 1, 2 and 3. out_last is high only on the final parity byte, and out_valid is low after it when no new start byte is offered.
- R3: The parity is the remainder of M(x)·x^(2t) divided by G(x) = (x+α^120)(x+α^121)…(x+α^(119+2t)). The field is GF(2^8) with α a root of x^8+x^7+x^2+x+1, and the earliest message byte is the highest-degree coefficient. The first parity byte sent is the highest-degree remainder coefficient.
- R4: The strength code is sampled on the accepted start beat. Changes on mode_sel later in the same codeword, including during parity, have no effect.
- R5: During the parity phase in_ready is low and out_valid is high. While out_ready is low the offered parity byte stays unchanged.
- R6: len_err is set when the beat count up to and including the in_eom beat differs from k, where k is 112, 178, 201 or 205 for codes 0 to 3. len_err is cleared by the next accepted start beat. Parity is still emitted in full when len_err is set.
- R7: Between codewords, an input byte without in_sop is accepted (in_ready high) and dropped (out_valid low).
- R8: An asynchronous active-low reset leaves out_valid low, len_err low and the block waiting for a start byte. This holds even when reset arrives part-way through a codeword.
- R9: A start byte may be offered in the cycle right after the final parity handshake, and it begins a fresh codeword with the division register cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Strength code 0..3, sampled on the start beat |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Message byte |
| in_sop | input | 1 | First byte of a codeword |
| in_eom | input | 1 | Final message byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Message or parity byte |
| out_last | output | 1 | Final parity byte of the codeword |
| len_err | output | 1 | Message length differed from k for the latched code |

## Verification
Message bytes are due on the output in the same cycle they are offered. The first parity byte is due in the cycle after the handshake of the in_eom byte, and each later parity byte follows one cycle after the previous one is taken. len_err is due one edge after the in_eom handshake. The bench drives inputs on the falling edge, samples one time unit later and before the next rising edge, and counts handshakes rather than cycles. This keeps its expectations aligned under random-looking stalls on both sides. Parity is compared against a remainder computed by long division in the bench for every strength, and len_err is read once the codeword has finished.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W   = 8;
  localparam int MAX_PAR = 20;
  localparam int N_MODES = 4;
  localparam int FCR     = 120;
  localparam int CNT_W   = 8;
  localparam logic [SYM_W:0] PRIM = 9'h187;
  localparam int PIDX_W  = $clog2(MAX_PAR);

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [MAX_PAR-1:0][SYM_W-1:0] sym_vec_t;
  typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAR} enc_st_e;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t p  = '0;
    sym_t aa = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa[SYM_W-1] ? ({aa[SYM_W-2:0], 1'b0} ^ PRIM[SYM_W-1:0])
                       : {aa[SYM_W-2:0], 1'b0};
    end
    return p;
  endfunction

  function automatic sym_t gf_apow(int e);
    sym_t r = 8'h01;
    for (int i = 0; i < e; i++) r = gf_mul(r, 8'h02);
    return r;
  endfunction

  function automatic int par_of(int m);
    return 14 + 2 * m;
  endfunction

  function automatic int k_of(logic [1:0] m);
    case (m)
      2'd0:    return 112;
      2'd1:    return 178;
      2'd2:    return 201;
      default: return 205;
    endcase
  endfunction

  // Low-order coefficients g[0..nr-1] of the monic generator with nr roots.
  function automatic sym_vec_t gen_coefs(int nr);
    sym_t     g [0:MAX_PAR];
    sym_t     root;
    sym_vec_t res;
    for (int j = 0; j <= MAX_PAR; j++) g[j] = '0;
    g[0] = 8'h01;
    for (int i = 0; i < nr; i++) begin
      root = gf_apow(FCR + i);
      for (int j = MAX_PAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
    end
    for (int j = 0; j < MAX_PAR; j++) res[j] = (j < nr) ? g[j] : '0;
    return res;
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_enc_pkg::*;
#(
  parameter sym_t C = 8'h01
) (
  input  sym_t a_i,
  output sym_t y_o
);
  always_comb y_o = gf_mul(a_i, C);
endmodule

// File: rtl/rs_div_lfsr.sv
module rs_div_lfsr
  import rs_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic       shift_i,
  input  sym_t       din_i,
  output sym_t       sym_o
);
  sym_vec_t r_q, base, r_d;
  logic [N_MODES-1:0][MAX_PAR-1:0][SYM_W-1:0] div_nxt, sh_nxt;
  logic [N_MODES-1:0][SYM_W-1:0] fb, top_sym;

  // A start beat divides from an empty register.
  assign base = clear_i ? '0 : r_q;

  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    localparam int       NP = par_of(m);
    localparam sym_vec_t GC = gen_coefs(NP);
    assign fb[m]      = din_i ^ base[NP-1];
    assign top_sym[m] = r_q[NP-1];
    for (genvar i = 0; i < MAX_PAR; i++) begin : g_stage
      if (i < NP) begin : g_used
        sym_t prod;
        rs_gf_cmul #(.C(GC[i])) u_mul (.a_i(fb[m]), .y_o(prod));
        if (i == 0) begin : g_first
          assign div_nxt[m][i] = prod;
          assign sh_nxt[m][i]  = '0;
        end else begin : g_rest
          assign div_nxt[m][i] = base[i-1] ^ prod;
          assign sh_nxt[m][i]  = r_q[i-1];
        end
      end else begin : g_unused
        assign div_nxt[m][i] = '0;
        assign sh_nxt[m][i]  = '0;
      end
    end
  end

  always_comb begin
    r_d = r_q;
    if (step_i)       r_d = div_nxt[mode_i];
    else if (shift_i) r_d = sh_nxt[mode_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else        r_q <= r_d;
  end

  assign sym_o = top_sym[mode_i];
endmodule

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl
  import rs_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic       in_eom_i,
  input  logic       out_ready_i,
  output logic       in_ready_o,
  output logic       msg_o,
  output logic       par_o,
  output logic [1:0] mode_o,
  output logic       clear_o,
  output logic       step_o,
  output logic       shift_o,
  output logic       last_o,
  output logic       len_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  enc_st_e             st_q;
  logic [1:0]          mode_q;
  logic [CNT_W-1:0]    cnt_q, beats, k_eff;
  logic [PIDX_W-1:0]   pidx_q, np_q;
  logic                len_err_q, acc, start, eom_acc;

  always_comb begin
    unique case (st_q)
      ST_IDLE: in_ready_o = in_sop_i ? out_ready_i : 1'b1;
      ST_MSG:  in_ready_o = out_ready_i;
      default: in_ready_o = 1'b0;
    endcase
  end

  assign acc     = in_valid_i & in_ready_o;
  assign start   = (st_q == ST_IDLE) & acc & in_sop_i;
  assign step_o  = start | ((st_q == ST_MSG) & acc);
  assign clear_o = start;
  assign eom_acc = step_o & in_eom_i;
  assign mode_o  = start ? mode_i : mode_q;
  assign beats   = start ? CNT_W'(1) : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1));
  assign k_eff   = CNT_W'(k_of(mode_o));
  assign np_q    = PIDX_W'(14) + {{(PIDX_W-3){1'b0}}, mode_q, 1'b0};
  assign shift_o = (st_q == ST_PAR) & out_ready_i;
  assign last_o  = (st_q == ST_PAR) & (pidx_q == np_q - PIDX_W'(1));
  assign msg_o   = (st_q == ST_MSG);
  assign par_o   = (st_q == ST_PAR);
  assign len_err_o = len_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mode_q    <= '0;
      cnt_q     <= '0;
      pidx_q    <= '0;
      len_err_q <= 1'b0;
    end else begin
      if (start)  mode_q <= mode_i;
      if (step_o) cnt_q  <= beats;
      if (eom_acc) begin
        len_err_q <= (beats != k_eff);
        st_q      <= ST_PAR;
        pidx_q    <= '0;
      end else if (start) begin
        len_err_q <= 1'b0;
        st_q      <= ST_MSG;
      end else if (shift_o) begin
        if (last_o) st_q   <= ST_IDLE;
        else        pidx_q <= pidx_q + PIDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/rs_sel_enc.sv
module rs_sel_enc
  import rs_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_eom,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             out_last,
  output logic             len_err
);
  logic       msg_ph, par_ph, clear, step, shift;
  logic [1:0] mode_eff;
  sym_t       par_sym;

  rs_seq_ctrl u_ctrl (
    .clk, .rst_n,
    .mode_i(mode_sel), .in_valid_i(in_valid), .in_sop_i(in_sop),
    .in_eom_i(in_eom), .out_ready_i(out_ready), .in_ready_o(in_ready),
    .msg_o(msg_ph), .par_o(par_ph), .mode_o(mode_eff), .clear_o(clear),
    .step_o(step), .shift_o(shift), .last_o(out_last), .len_err_o(len_err)
  );

  rs_div_lfsr u_div (
    .clk, .rst_n,
    .mode_i(mode_eff), .clear_i(clear), .step_i(step), .shift_i(shift),
    .din_i(in_data), .sym_o(par_sym)
  );

  assign out_valid = par_ph | (in_valid & (msg_ph | in_sop));
  assign out_data  = par_ph ? par_sym : in_data;
endmodule

// File: rtl/rs_sel_enc_chk.sv
module rs_sel_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sop,
  input logic       in_eom,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       len_err,
  input logic       msg_ph,
  input logic       par_ph
);
  AST_MSG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ph && in_valid |-> out_valid && out_data == in_data); // R1
  AST_PAR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_ph) |-> $past(in_valid && in_ready && in_eom)); // R2
  AST_LAST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !par_ph); // R2
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    par_ph && out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_PAR_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    par_ph |-> !in_ready && out_valid); // R5
  AST_ERR_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_err) |-> $past(in_valid && in_ready)); // R6
  AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ph && !par_ph && in_valid && !in_sop |-> in_ready && !out_valid); // R7
endmodule

bind rs_sel_enc rs_sel_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sop(in_sop), .in_eom(in_eom), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .len_err(len_err), .msg_ph(msg_ph), .par_ph(par_ph)
);

// File: tb/rs_sel_enc_bench.sv
module rs_sel_enc_bench;
  localparam int PERIOD = 10;
  localparam int NV = 10;
  // mode[23:22] pat[21:20] adj[19:16] seed[15:8] exp_err[1] bp[0]
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'd0, 8'd11, 6'd0, 1'b0, 1'b0},
    {2'd1, 2'd0, 4'd0, 8'd22, 6'd0, 1'b0, 1'b1},
    {2'd2, 2'd0, 4'd0, 8'd33, 6'd0, 1'b0, 1'b0},
    {2'd3, 2'd0, 4'd0, 8'd44, 6'd0, 1'b0, 1'b1},
    {2'd3, 2'd1, 4'd0, 8'd0,  6'd0, 1'b0, 1'b0},
    {2'd0, 2'd2, 4'd0, 8'd0,  6'd0, 1'b0, 1'b1},
    {2'd2, 2'd0, 4'd1, 8'd66, 6'd0, 1'b1, 1'b0},
    {2'd1, 2'd0, 4'd2, 8'd77, 6'd0, 1'b1, 1'b1},
    {2'd3, 2'd0, 4'd3, 8'd88, 6'd0, 1'b1, 1'b0},
    {2'd1, 2'd0, 4'd0, 8'd99, 6'd0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_sel = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eom = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last, len_err;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] msg [0:255];
  logic [7:0] work [0:279];
  logic [7:0] gh [0:20];
  logic [7:0] got_par [0:19];

  rs_sel_enc u_rs_sel_enc (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bm(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = '0;
    for (int i = 7; i >= 0; i--) begin
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h87 : 8'h00);
      if (a[i]) p = p ^ b;
    end
    return p;
  endfunction

  function automatic int kval(int m);
    return (m == 0) ? 112 : (m == 1) ? 178 : (m == 2) ? 201 : 205;
  endfunction

  task automatic build_gen(input int nr);
    logic [7:0] r;
    for (int j = 0; j <= 20; j++) gh[j] = '0;
    gh[0] = 8'h01;
    for (int i = 0; i < nr; i++) begin
      r = 8'h01;
      for (int e = 0; e < 120 + i; e++) r = bm(r, 8'h02);
      for (int j = i + 1; j >= 1; j--) gh[j] = gh[j] ^ bm(gh[j-1], r);
    end
  endtask

  task automatic ref_div(input int len, input int nr);
    logic [7:0] c;
    for (int i = 0; i < 280; i++) work[i] = (i < len) ? msg[i] : 8'h00;
    for (int i = 0; i < len; i++) begin
      c = work[i];
      for (int j = 1; j <= nr; j++) work[i+j] = work[i+j] ^ bm(c, gh[j]);
    end
  endtask

  task automatic run_frame(input int mode, input int pat, input int adj, input int seed,
                           input bit bp, input bit exp_err);
    int np, len, i_in, o_cnt, cyc, pass_bad, last_bad, par_bad;
    bit ready_bad, hold_bad, prev_stall;
    logic [7:0] prev_data;
    np  = 14 + 2 * mode;
    len = kval(mode) + ((adj == 1) ? -1 : (adj == 2) ? 1 : (adj == 3) ? 1 - kval(mode) : 0);
    for (int i = 0; i < len; i++)
      msg[i] = (pat == 1) ? 8'h00 : (pat == 2) ? 8'hFF
             : 8'((seed * 7 + i * 29 + (i * i) / 3) ^ (i >> 2));
    build_gen(np);
    ref_div(len, np);
    i_in = 0; o_cnt = 0; cyc = 0; pass_bad = 0; last_bad = 0; par_bad = 0;
    ready_bad = 0; hold_bad = 0; prev_stall = 0; prev_data = '0;
    while (o_cnt < len + np && cyc < 4000) begin
      @(negedge clk);
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      if (i_in < len) begin
        in_valid = !(bp && cyc % 4 == 3);
        in_data  = msg[i_in];
        in_sop   = (i_in == 0);
        in_eom   = (i_in == len - 1);
        mode_sel = (i_in == 0) ? 2'(mode) : 2'(mode + 1 + cyc); // R4 stimulus
      end else begin
        in_valid = 1'b1; in_data = 8'h5A; in_sop = 1'b0; in_eom = 1'b0;
        mode_sel = 2'(cyc);
      end
      #1;
      if (o_cnt >= len && in_ready) ready_bad = 1;
      if (prev_stall && out_data != prev_data) hold_bad = 1;
      prev_stall = (o_cnt >= len) && out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (o_cnt < len) begin
          if (out_data != msg[o_cnt]) pass_bad++;
        end else got_par[o_cnt-len] = out_data;
        if (out_last != (o_cnt == len + np - 1)) last_bad++;
        o_cnt++;
      end
      if (in_valid && in_ready && i_in < len) i_in++;
      cyc++;
    end
    for (int j = 0; j < np; j++) if (got_par[j] != work[len+j]) par_bad++;
    chk(pass_bad == 0, "R1", "message bytes altered", pass_bad, 0);
    chk(par_bad == 0 && o_cnt == len + np, "R3 R4", "parity bytes wrong", par_bad, 0);
    chk(last_bad == 0, "R2", "out_last misplaced", last_bad, 0);
    chk(!ready_bad, "R5", "in_ready high in parity phase", ready_bad, 0);
    if (bp) chk(!hold_bad, "R5", "parity changed while stalled", hold_bad, 0);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eom = 1'b0; out_ready = 1'b1;
    #1;
    chk(!out_valid, "R2", "extra output after last parity", out_valid, 0);
    chk(len_err == exp_err, "R6", "len_err after codeword", len_err, exp_err);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk(!out_valid && !len_err, "R8", "outputs during reset", {out_valid, len_err}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid && !len_err && in_ready, "R8", "state after reset",
        {out_valid, len_err, in_ready}, 1);
    // R7: stray byte between codewords is taken and dropped
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hAB; out_ready = 1'b0;
    #1;
    chk(in_ready && !out_valid, "R7", "stray byte handling", {in_ready, out_valid}, 2);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    // R9: table frames run back to back
    for (int v = 0; v < NV; v++)
      run_frame(int'(VEC[v][23:22]), int'(VEC[v][21:20]), int'(VEC[v][19:16]),
                int'(VEC[v][15:8]), VEC[v][0], VEC[v][1]);
    // R8: reset in the middle of a codeword after an error frame
    run_frame(3, 0, 3, 5, 1'b0, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_eom = 1'b0; in_data = 8'h11; mode_sel = 2'd2;
    @(negedge clk);
    in_sop = 1'b0; in_data = 8'h22;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk(!out_valid && !len_err, "R8", "mid-codeword reset", {out_valid, len_err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(0, 0, 0, 11, 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule